// File: doc/BRIEF.md
# Multiphase Regulator Fault Sequencer

This block is the synchronous supervisor of a multiphase buck regulator. The analog side (comparators, soft-start capacitor, current-sense amplifiers) is outside; it delivers level flags that the block synchronizes, qualifies and turns into the per-phase drive mode, the soft-start charge and discharge controls, the open-drain power-good pull-down and an over-voltage trip output. Supply and input-divider power-on-reset flags gate start-up, and their drop is the only way out of either latched fault.

The sequencer runs six named states. S_IDLE holds all phases at high impedance until both power-on-reset flags are good, then moves to S_RUN, where phases switch normally and the soft-start capacitor charges. A qualified over-current on any phase takes S_RUN to S_HIC_WAIT (phases at high impedance, capacitor left alone) until the soft-start level is below its upper threshold, then to S_HIC_DRAIN (capacitor discharging) until the level is below its lower threshold, and back to S_RUN. The over-current event that reaches the retry limit goes to S_OCP_LOCK instead. A qualified over-voltage from any state with reset good goes to S_OVP_LOCK, which drives every phase low. Loss of either reset flag returns any state to S_IDLE and clears the event count.

Top module: `mpr_fault_seq`

## Requirements
- R1: While rst_n is low and after its release with both reset flags low, every phase mode is high impedance (2'b10), ss_charge and ss_discharge are 0, pg_pull_low is 1 and ovp_trip is 0.
- R2: Only when vcc_por_ok and vin_por_ok are both high does the block enter S_RUN, three clock edges after the later flag rises: every phase mode becomes normal PWM (2'b01) and ss_charge becomes 1.
- R3: A fault flag (ovp_flag or any bit of ocp_flag) acts only after it has been high for FAULT_HOLD consecutive cycles past the two-stage synchronizer; outputs change on edge FAULT_HOLD+3 after the flag rises, and a shorter pulse is ignored.
- R4: A qualified over-voltage drives every phase mode low (2'b00), sets ovp_trip, clears ss_charge, and holds after the flag drops.
- R5: Over-voltage takes priority over over-current, both when qualified together and while over-current is locked or in hiccup.
- R6: S_OVP_LOCK and S_OCP_LOCK are left only when either reset flag drops; the block then sits in S_IDLE and restarts when both return.
- R7: A qualified over-current on any phase in S_RUN sets all phase modes to high impedance with ss_charge 0; ss_discharge rises only after ss_below_hi is seen, and S_RUN resumes after ss_below_lo is seen.
- R8: The MAX_OCP-th over-current event since the last reset-good entry (third by default) enters S_OCP_LOCK: high impedance, no charge, no discharge, held regardless of soft-start flags; the event count restarts from zero after a reset-flag drop.
- R9: In S_RUN, pg_pull_low follows the inverse of pg_above three edges after it changes; in every other state pg_pull_low is 1.
- R10: While vid_busy (synchronized) is high, the power-good state does not change; it resumes tracking three edges after vid_busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_por_ok | input | 1 | Supply power-on-reset threshold reached |
| vin_por_ok | input | 1 | Input-divider power-on-reset threshold reached |
| ovp_flag | input | 1 | Output at or above 140% of target |
| pg_above | input | 1 | Output at or above 92% of target |
| ocp_flag | input | NPH | Per-phase over-current comparator |
| ss_below_hi | input | 1 | Soft-start level below 90% of supply |
| ss_below_lo | input | 1 | Soft-start level below 0.2 V |
| vid_busy | input | 1 | Voltage-ID change in progress |
| phase_mode | output | 2*NPH | Per-phase mode: 00 low, 01 PWM, 10 high impedance |
| ss_charge | output | 1 | Enable soft-start charge current |
| ss_discharge | output | 1 | Enable soft-start discharge current |
| pg_pull_low | output | 1 | Open-drain power-good pull-down enable |
| ovp_trip | output | 1 | Over-voltage trip indication |

## Verification
Reset-flag, soft-start, power-good and voltage-ID inputs reach the outputs on the third clock edge after they change (two synchronizer stages plus the state or power-good register), and fault flags on edge FAULT_HOLD+3. The bench drives every input just after a rising edge, counts edges with a tick task and samples one time unit after the due edge; for the filter and the freeze it also samples one edge early to prove nothing changed prematurely. Hiccup, lock and priority scenarios each hold the fault only long enough to be qualified, so later checks see a known filter state.

// File: rtl/mprfs_pkg.sv
package mprfs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_HIC_WAIT,
        S_HIC_DRAIN,
        S_OCP_LOCK,
        S_OVP_LOCK
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_LOW = 2'b00,
        PH_PWM = 2'b01,
        PH_HIZ = 2'b10
    } ph_mode_t;
endpackage

// File: rtl/mprfs_sync.sv
module mprfs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/mprfs_hold_filter.sv
module mprfs_hold_filter #(
    parameter int W    = 1,
    parameter int HOLD = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!d[g])         cnt <= '0;
            else if (cnt != HOLD_C) cnt <= cnt + 1'b1;
        end

        assign q[g] = (cnt == HOLD_C);

        p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= HOLD_C);
        p_qual_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[g]) |-> $past(d[g]));
    end
endmodule

// File: rtl/mpr_fault_seq.sv
module mpr_fault_seq
    import mprfs_pkg::*;
#(
    parameter int NPH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FAULT_HOLD  = 4,
    parameter int MAX_OCP     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vcc_por_ok,
    input  logic             vin_por_ok,
    input  logic             ovp_flag,
    input  logic             pg_above,
    input  logic [NPH-1:0]   ocp_flag,
    input  logic             ss_below_hi,
    input  logic             ss_below_lo,
    input  logic             vid_busy,
    output logic [2*NPH-1:0] phase_mode,
    output logic             ss_charge,
    output logic             ss_discharge,
    output logic             pg_pull_low,
    output logic             ovp_trip
);
    localparam int NLVL = 6;
    localparam int NFLT = NPH + 1;
    localparam int CCW  = $clog2(MAX_OCP + 1);
    localparam logic [CCW-1:0] OCP_LAST = CCW'(MAX_OCP - 1);
    localparam logic [CCW-1:0] OCP_MAX  = CCW'(MAX_OCP);

    // level inputs: synchronized only
    logic [NLVL-1:0] lvl_s;
    mprfs_sync #(.W(NLVL), .STAGES(SYNC_STAGES)) i_lvl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({vcc_por_ok, vin_por_ok, pg_above, ss_below_hi, ss_below_lo, vid_busy}),
        .q(lvl_s)
    );
    logic por_s, pg_s, ss_hi_s, ss_lo_s, vid_s;
    assign por_s   = lvl_s[5] & lvl_s[4];
    assign pg_s    = lvl_s[3];
    assign ss_hi_s = lvl_s[2];
    assign ss_lo_s = lvl_s[1];
    assign vid_s   = lvl_s[0];

    // fault inputs: synchronized, then held-cycle qualified
    logic [NFLT-1:0] flt_s, flt_q;
    mprfs_sync #(.W(NFLT), .STAGES(SYNC_STAGES)) i_flt_sync (
        .clk(clk), .rst_n(rst_n), .d({ovp_flag, ocp_flag}), .q(flt_s)
    );
    mprfs_hold_filter #(.W(NFLT), .HOLD(FAULT_HOLD)) i_flt_hold (
        .clk(clk), .rst_n(rst_n), .d(flt_s), .q(flt_q)
    );
    logic ovp_q, ocp_any;
    assign ovp_q   = flt_q[NPH];
    assign ocp_any = |flt_q[NPH-1:0];

    seq_state_t st, nxt;
    logic [CCW-1:0] ocp_cnt;
    logic pg_good;

    always_comb begin
        nxt = st;
        if (!por_s) begin
            nxt = S_IDLE;
        end else if (ovp_q) begin
            nxt = S_OVP_LOCK;
        end else begin
            unique case (st)
                S_IDLE:      nxt = S_RUN;
                S_RUN:       if (ocp_any)
                                 nxt = (ocp_cnt == OCP_LAST) ? S_OCP_LOCK : S_HIC_WAIT;
                S_HIC_WAIT:  if (ss_hi_s) nxt = S_HIC_DRAIN;
                S_HIC_DRAIN: if (ss_lo_s) nxt = S_RUN;
                S_OCP_LOCK:  nxt = S_OCP_LOCK;
                S_OVP_LOCK:  nxt = S_OVP_LOCK;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // hiccup event count and power-good state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocp_cnt <= '0;
            pg_good <= 1'b0;
        end else begin
            if (!por_s)
                ocp_cnt <= '0;
            else if (st == S_RUN && (nxt == S_HIC_WAIT || nxt == S_OCP_LOCK))
                ocp_cnt <= ocp_cnt + 1'b1;

            if (st != S_RUN) pg_good <= 1'b0;
            else if (!vid_s) pg_good <= pg_s;
        end
    end

    // outputs
    ph_mode_t mode;
    always_comb begin
        mode         = PH_HIZ;
        ss_charge    = 1'b0;
        ss_discharge = 1'b0;
        ovp_trip     = 1'b0;
        unique case (st)
            S_IDLE:      mode = PH_HIZ;
            S_RUN:       begin mode = PH_PWM; ss_charge = 1'b1; end
            S_HIC_WAIT:  mode = PH_HIZ;
            S_HIC_DRAIN: begin mode = PH_HIZ; ss_discharge = 1'b1; end
            S_OCP_LOCK:  mode = PH_HIZ;
            S_OVP_LOCK:  begin mode = PH_LOW; ovp_trip = 1'b1; end
            default:     mode = PH_HIZ;
        endcase
    end
    assign phase_mode  = {NPH{mode}};
    assign pg_pull_low = (st != S_RUN) | !pg_good;

    p_start_needs_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_charge) |-> $past(por_s));
    p_ovp_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovp_trip) |-> $past(ovp_q));
    p_ovp_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_trip && por_s) |=> ovp_trip);
    p_drain_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_discharge) |-> $past(ss_hi_s));
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OCP_LOCK && por_s && !ovp_q) |=> (st == S_OCP_LOCK));
    p_cnt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_cnt <= OCP_MAX);
    p_pg_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && $past(st == S_RUN) && $past(vid_s)) |-> $stable(pg_good));
endmodule

// File: tb/test_mpr_fault_seq.sv
module test_mpr_fault_seq;
    localparam int NPH = 4;
    localparam int QUAL = 7;              // FAULT_HOLD(4) + 3 edges
    localparam logic [7:0] M_HIZ = 8'hAA;
    localparam logic [7:0] M_PWM = 8'h55;
    localparam logic [7:0] M_LOW = 8'h00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_por_ok = 0, vin_por_ok = 0, ovp_flag = 0, pg_above = 0;
    logic [NPH-1:0] ocp_flag = '0;
    logic ss_below_hi = 0, ss_below_lo = 0, vid_busy = 0;
    logic [2*NPH-1:0] phase_mode;
    logic ss_charge, ss_discharge, pg_pull_low, ovp_trip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mpr_fault_seq i_mpr_fault_seq (
        .clk(clk), .rst_n(rst_n), .vcc_por_ok(vcc_por_ok), .vin_por_ok(vin_por_ok),
        .ovp_flag(ovp_flag), .pg_above(pg_above), .ocp_flag(ocp_flag),
        .ss_below_hi(ss_below_hi), .ss_below_lo(ss_below_lo), .vid_busy(vid_busy),
        .phase_mode(phase_mode), .ss_charge(ss_charge), .ss_discharge(ss_discharge),
        .pg_pull_low(pg_pull_low), .ovp_trip(ovp_trip)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one qualified over-current pulse on a phase, released once acted on
    task automatic ocp_event(input int ph);
        ocp_flag[ph] = 1'b1;
        tick(QUAL);
        ocp_flag[ph] = 1'b0;
    endtask

    // walk a hiccup back to S_RUN
    task automatic run_hiccup(input string req);
        tick(4);
        chk({req, " no discharge before upper ss flag"}, ss_discharge, 1'b0);
        ss_below_hi = 1'b1;
        tick(3);
        chk({req, " discharge on"}, ss_discharge, 1'b1);
        ss_below_lo = 1'b1;
        tick(3);
        chk({req, " restart pwm"}, phase_mode, M_PWM);
        chk({req, " restart charge"}, {ss_charge, ss_discharge}, 2'b10);
        ss_below_hi = 1'b0;
        ss_below_lo = 1'b0;
        tick(3);
    endtask

    task automatic t_reset;
        tick(3);
        chk("R1 mode in reset", phase_mode, M_HIZ);
        rst_n = 1'b1;
        tick(5);
        chk("R1 mode after reset", phase_mode, M_HIZ);
        chk("R1 ss ctl", {ss_charge, ss_discharge}, 2'b00);
        chk("R1 pg low", pg_pull_low, 1'b1);
        chk("R1 ovp trip", ovp_trip, 1'b0);
    endtask

    task automatic t_start;
        vcc_por_ok = 1'b1;
        tick(10);
        chk("R2 one por flag idle", phase_mode, M_HIZ);
        vin_por_ok = 1'b1;
        tick(2);
        chk("R2 not yet run", ss_charge, 1'b0);
        tick(1);
        chk("R2 run mode", phase_mode, M_PWM);
        chk("R2 charge", ss_charge, 1'b1);
    endtask

    task automatic t_pgood;
        pg_above = 1'b1;
        tick(3);
        chk("R9 pg released", pg_pull_low, 1'b0);
        vid_busy = 1'b1;
        tick(3);
        pg_above = 1'b0;
        tick(5);
        chk("R10 pg frozen", pg_pull_low, 1'b0);
        vid_busy = 1'b0;
        tick(2);
        chk("R10 still frozen edge 2", pg_pull_low, 1'b0);
        tick(1);
        chk("R10 tracks again", pg_pull_low, 1'b1);
        pg_above = 1'b1;
        tick(3);
        chk("R9 pg back", pg_pull_low, 1'b0);
    endtask

    task automatic t_filter_hiccup;
        ocp_flag[1] = 1'b1;
        tick(3);
        ocp_flag[1] = 1'b0;
        tick(10);
        chk("R3 short pulse ignored", phase_mode, M_PWM);
        ocp_flag[2] = 1'b1;
        tick(QUAL - 1);
        chk("R3 not before hold", phase_mode, M_PWM);
        tick(1);
        ocp_flag[2] = 1'b0;
        chk("R7 hiz on ocp", phase_mode, M_HIZ);
        chk("R7 no charge", ss_charge, 1'b0);
        chk("R9 pg low outside run", pg_pull_low, 1'b1);
        run_hiccup("R7 event1");
    endtask

    task automatic t_lockout;
        ocp_event(0);
        chk("R7 event2 hiz", phase_mode, M_HIZ);
        run_hiccup("R7 event2");
        ocp_event(3);
        chk("R8 locked hiz", phase_mode, M_HIZ);
        ss_below_hi = 1'b1;
        ss_below_lo = 1'b1;
        tick(10);
        chk("R8 lock held", {phase_mode, ss_charge, ss_discharge}, {M_HIZ, 2'b00});
        ss_below_hi = 1'b0;
        ss_below_lo = 1'b0;
        vcc_por_ok = 1'b0;
        tick(3);
        chk("R6 idle after por drop", {phase_mode, ss_charge}, {M_HIZ, 1'b0});
        vcc_por_ok = 1'b1;
        tick(3);
        chk("R6 restart", phase_mode, M_PWM);
        ocp_event(1);
        chk("R8 count cleared (hiccup, not lock)", phase_mode, M_HIZ);
        run_hiccup("R8 after clear");
    endtask

    task automatic t_ovp;
        ovp_flag = 1'b1;
        tick(QUAL - 1);
        chk("R3 ovp not before hold", ovp_trip, 1'b0);
        tick(1);
        ovp_flag = 1'b0;
        chk("R4 all low", phase_mode, M_LOW);
        chk("R4 trip/charge", {ovp_trip, ss_charge}, 2'b10);
        ocp_event(0);
        tick(5);
        chk("R4 latched", {phase_mode, ovp_trip}, {M_LOW, 1'b1});
        chk("R5 ocp no effect in ovp", phase_mode, M_LOW);
        vin_por_ok = 1'b0;
        tick(3);
        chk("R6 ovp cleared by por", {phase_mode, ovp_trip}, {M_HIZ, 1'b0});
        vin_por_ok = 1'b1;
        tick(3);
        chk("R6 ovp restart", phase_mode, M_PWM);
    endtask

    task automatic t_priority;
        ovp_flag = 1'b1;
        ocp_flag[0] = 1'b1;
        tick(QUAL);
        ovp_flag = 1'b0;
        ocp_flag[0] = 1'b0;
        chk("R5 ovp wins", {phase_mode, ovp_trip}, {M_LOW, 1'b1});
        vcc_por_ok = 1'b0;
        tick(3);
        vcc_por_ok = 1'b1;
        tick(3);
        ocp_event(2);
        chk("R5 hiccup entered", phase_mode, M_HIZ);
        ovp_flag = 1'b1;
        tick(QUAL);
        ovp_flag = 1'b0;
        chk("R5 ovp overrides hiccup", {phase_mode, ovp_trip}, {M_LOW, 1'b1});
    endtask

    initial begin
        #1;
        t_reset();
        t_start();
        t_pgood();
        t_filter_hiccup();
        t_lockout();
        t_ovp();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule